// File: doc/BRIEF.md
# Stoppable Divided Clock Generator

This block derives a set of processor clocks from one fast reference clock. The main clock runs at one third of the reference rate. A companion clock covers half of every main-clock period, and a peripheral clock toggles on each falling edge of the main clock. A slow speed option stretches every phase by a further fixed factor. An oscillator-enable output tells the external oscillator whether it may run.

A processor halts its own clocks by placing an idle status code and then a stop status code on its status pins, one on each of two consecutive rising edges of the main clock. The outputs then freeze. The main and companion clocks are held high, and the peripheral clock keeps the level it had. A rising edge on the start input, or a reset, wakes the block. Before the outputs run again, a crystal source waits through a long stabilisation count, while an external source resumes within a few reference cycles. The source select and the speed select are captured while reset is low. Halting and restarting do not change them.

The control machine has four states. RUN is the normal running state. HALT freezes the outputs. WARM counts the crystal stabilisation time. RESUME is the short wait for an external source. The transitions are:
- RUN→HALT on a recognised stop sequence.
- HALT→WARM on a start edge in crystal mode.
- HALT→RESUME on a start edge in external mode.
- WARM→RUN at terminal count.
- RESUME→RUN after the short wait.
- Any state→RUN on reset.

Top module: `stopclk_gen`

## Requirements
- R1: In fast mode the main clock is high for one reference cycle and low for two. The peripheral clock toggles on every falling main-clock edge. The first falling edge comes on the first reference edge after reset is released.
- R2: In fast mode the companion clock is high for three consecutive half reference cycles out of every six. The high time starts when the main clock rises.
- R3: In slow mode (slow_sel = 1 at reset), each clock phase lasts SLOW_DIV (16) reference cycles. The main clock is high for 16 cycles and low for 32. The companion clock is high for the 16 main-high cycles and the first 8 cycles after the main clock falls.
- R4: The status bits are sampled only on the reference edge where the main clock rises. A halt is taken only when 011 (status[2]=0, status[1]=1, status[0]=1) is sampled and 111 was sampled on the previous rising edge. Any other order leaves the clocks running.
- R5: From the halting rising edge onwards, the main and companion clocks stay high and the peripheral clock holds its level until a restart.
- R6: While start is high, a stop sequence does not halt the clocks. A start edge while running has no effect.
- R7: osc_en is low while halted with a crystal source (src_ext = 0 at reset). It is high in every other state, and always high with an external source.
- R8: External source: if a start rise is seen at reference edge s, the main clock falls at edge s+2.
- R9: Crystal source: if a start rise is seen at edge s, the main clock stays high through edge s+WARM_COUNT (8192) and falls at edge s+WARM_COUNT+1.
- R10: src_ext and slow_sel are captured while rst_n is low. Later changes have no effect. The speed mode after a restart is the one in force before the halt.
- R11: Reset is synchronous and active-low. During reset the main and companion clocks are high, the peripheral clock is low and osc_en is high. Reset from any state, including a halt, returns to running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_ext | input | 1 | Source select captured at reset: 1 external, 0 crystal |
| start | input | 1 | Restart request (rising edge); high level blocks halting |
| status | input | 3 | Processor status code |
| slow_sel | input | 1 | Speed select captured at reset: 1 slow |
| clk_out | output | 1 | Main clock, one third of reference |
| clk50_out | output | 1 | 50% duty companion clock |
| pclk_out | output | 1 | Peripheral clock, half the main rate |
| osc_en | output | 1 | Oscillator enable |

## Verification
The stop decoder is driven with three status patterns. The first is a lone stop code with no idle code before it. The second puts an unrelated code between idle and stop. The third is the correct idle-then-stop pair. Only the last may freeze the outputs, so this shows whether the decoder really demands back-to-back samples. The correct pair is also sent with start held high, which shows whether the level gate works. Restart is tried from external and crystal sources and in slow and fast speeds. This separates the two wake-up latencies and shows whether speed is kept across a halt. The selects are also toggled after reset to show they were latched.

// File: rtl/stopclk_pkg.sv
`timescale 1ns/1ps
package stopclk_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_WARM   = 2'd2,
        ST_RESUME = 2'd3
    } run_state_t;

    typedef enum logic [2:0] {
        PH_HIGH  = 3'b001,
        PH_LOW_A = 3'b010,
        PH_LOW_B = 3'b100
    } phase_t;

    localparam logic [2:0] STAT_IDLE = 3'b111;
    localparam logic [2:0] STAT_STOP = 3'b011;

endpackage

// File: rtl/stopclk_div.sv
`timescale 1ns/1ps
module stopclk_div
    import stopclk_pkg::*;
#(
    parameter int SLOW_DIV = 16
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic clk_o,
    output logic clk50_o,
    output logic pclk_o,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int PW   = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam int HALF = SLOW_DIV / 2;

    logic [PW-1:0] pre_q, pre_d;
    phase_t        ph_q, ph_d;
    logic          tick;
    logic          pclk_q;
    logic          slow_ext_q;
    logic          fast_ext_q;

    always_comb begin
        tick  = slow ? (pre_q == PW'(SLOW_DIV - 1)) : 1'b1;
        pre_d = pre_q;
        ph_d  = ph_q;
        if (run) begin
            pre_d = tick ? '0 : pre_q + 1'b1;
            if (tick) begin
                unique case (ph_q)
                    PH_HIGH:  ph_d = PH_LOW_A;
                    PH_LOW_A: ph_d = PH_LOW_B;
                    PH_LOW_B: ph_d = PH_HIGH;
                    default:  ph_d = PH_HIGH;
                endcase
            end
        end
    end

    assign rise_evt = run & tick & (ph_q == PH_LOW_B);
    assign fall_evt = run & tick & (ph_q == PH_HIGH);

    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            pre_q      <= '0;
            ph_q       <= PH_HIGH;
            pclk_q     <= 1'b0;
            slow_ext_q <= 1'b0;
        end else begin
            pre_q      <= pre_d;
            ph_q       <= ph_d;
            slow_ext_q <= (ph_d == PH_LOW_A) && (pre_d < PW'(HALF));
            if (fall_evt) begin
                pclk_q <= ~pclk_q;
            end
        end
    end

    // half-cycle extension of the high phase for the fast speed
    always_ff @(negedge ref_clk) begin
        if (!rst_n) begin
            fast_ext_q <= 1'b1;
        end else begin
            fast_ext_q <= ph_q[0];
        end
    end

    assign clk_o   = ph_q[0];
    assign clk50_o = ph_q[0] | (slow ? slow_ext_q : fast_ext_q);
    assign pclk_o  = pclk_q;

endmodule

// File: rtl/stopclk_stat.sv
`timescale 1ns/1ps
module stopclk_stat
    import stopclk_pkg::*;
(
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       sample,
    input  logic       armed,
    input  logic       start,
    input  logic [2:0] status,
    output logic       halt_req
);
    logic idle_seen_q;

    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            idle_seen_q <= 1'b0;
        end else if (!armed) begin
            idle_seen_q <= 1'b0;
        end else if (sample) begin
            idle_seen_q <= (status == STAT_IDLE);
        end
    end

    assign halt_req = sample & armed & idle_seen_q & (status == STAT_STOP) & ~start;

endmodule

// File: rtl/stopclk_ctrl.sv
`timescale 1ns/1ps
module stopclk_ctrl
    import stopclk_pkg::*;
#(
    parameter int WARM_COUNT    = 8192,
    parameter int RESUME_CYCLES = 1
) (
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       xtal,
    input  logic       start,
    input  logic       halt_req,
    output logic       run,
    output logic       osc_en,
    output run_state_t state_o
);
    localparam int MAXC = (WARM_COUNT > RESUME_CYCLES) ? WARM_COUNT : RESUME_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    run_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          start_q;
    logic          start_rise;

    assign start_rise = start & ~start_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (halt_req)   state_d = ST_HALT;
            ST_HALT:   if (start_rise) state_d = xtal ? ST_WARM : ST_RESUME;
            ST_WARM:   if (cnt_q == CW'(WARM_COUNT - 1))    state_d = ST_RUN;
            ST_RESUME: if (cnt_q == CW'(RESUME_CYCLES - 1)) state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            start_q <= start;
        end else begin
            state_q <= state_d;
            start_q <= start;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (state_q == ST_WARM || state_q == ST_RESUME) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        run     = (state_q == ST_RUN);
        osc_en  = ~(xtal && state_q == ST_HALT);
        state_o = state_q;
    end

endmodule

// File: rtl/stopclk_gen.sv
`timescale 1ns/1ps
module stopclk_gen
    import stopclk_pkg::*;
#(
    parameter int WARM_COUNT    = 8192,
    parameter int RESUME_CYCLES = 1,
    parameter int SLOW_DIV      = 16
) (
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       src_ext,
    input  logic       start,
    input  logic [2:0] status,
    input  logic       slow_sel,
    output logic       clk_out,
    output logic       clk50_out,
    output logic       pclk_out,
    output logic       osc_en
);
    logic       xtal_q;
    logic       slow_q;
    logic       running;
    logic       rise_evt;
    logic       fall_evt;
    logic       halt_req;
    run_state_t state_q;

    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            xtal_q <= ~src_ext;
            slow_q <= slow_sel;
        end
    end

    stopclk_div #(.SLOW_DIV(SLOW_DIV)) u_div (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .run      (running),
        .slow     (slow_q),
        .clk_o    (clk_out),
        .clk50_o  (clk50_out),
        .pclk_o   (pclk_out),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    stopclk_stat u_stat (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .sample   (rise_evt),
        .armed    (running),
        .start    (start),
        .status   (status),
        .halt_req (halt_req)
    );

    stopclk_ctrl #(
        .WARM_COUNT    (WARM_COUNT),
        .RESUME_CYCLES (RESUME_CYCLES)
    ) u_ctrl (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .xtal     (xtal_q),
        .start    (start),
        .halt_req (halt_req),
        .run      (running),
        .osc_en   (osc_en),
        .state_o  (state_q)
    );

endmodule

// File: rtl/stopclk_gen_chk.sv
`timescale 1ns/1ps
module stopclk_gen_chk
    import stopclk_pkg::*;
(
    input logic       ref_clk,
    input logic       rst_n,
    input logic       start,
    input logic [2:0] status,
    input logic       clk_out,
    input logic       clk50_out,
    input logic       pclk_out,
    input logic       osc_en,
    input logic       xtal_q,
    input logic       slow_q,
    input logic       rise_evt,
    input run_state_t state_q
);
    logic [3:0] resume_len;
    logic       halted;
    logic       running;

    assign halted  = (state_q == ST_HALT);
    assign running = (state_q == ST_RUN);

    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            resume_len <= '0;
        end else if (state_q == ST_RESUME && resume_len != 4'hF) begin
            resume_len <= resume_len + 1'b1;
        end else if (state_q != ST_RESUME) begin
            resume_len <= '0;
        end
    end

    a_r1_two_low: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($rose(clk_out) && !slow_q) |-> !$past(clk_out, 2));

    a_r4_needs_stop_code: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (running && rise_evt && status != STAT_STOP) |=> !halted);

    a_r5_frozen: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> (clk_out && clk50_out && $stable(pclk_out)));

    a_r6_start_blocks: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (start && running) |=> !halted);

    a_r7_osc_off: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (halted && xtal_q) |-> !osc_en);

    a_r7_osc_ext: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !xtal_q |-> osc_en);

    a_r8_resume_bound: assert property (@(posedge ref_clk) disable iff (!rst_n)
        resume_len < 4'd3);

    a_r9_warm_high: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == ST_WARM) |-> (clk_out && clk50_out));

endmodule

bind stopclk_gen stopclk_gen_chk i_chk (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .start     (start),
    .status    (status),
    .clk_out   (clk_out),
    .clk50_out (clk50_out),
    .pclk_out  (pclk_out),
    .osc_en    (osc_en),
    .xtal_q    (xtal_q),
    .slow_q    (slow_q),
    .rise_evt  (rise_evt),
    .state_q   (state_q)
);

// File: tb/test_stopclk_gen.sv
`timescale 1ns/1ps
module test_stopclk_gen;
    localparam int WARM = 8192;

    logic       ref_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       src_ext = 1'b1;
    logic       start   = 1'b0;
    logic [2:0] status  = 3'b000;
    logic       slow_sel = 1'b0;
    logic       clk_out, clk50_out, pclk_out, osc_en;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    typedef struct {
        int         cyc;
        bit         half;
        logic [3:0] exp;
        logic [3:0] mask;
        string      req;
    } item_t;
    item_t sb_q[$];

    always #2.5 ref_clk = ~ref_clk;

    stopclk_gen i_stopclk_gen (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .src_ext   (src_ext),
        .start     (start),
        .status    (status),
        .slow_sel  (slow_sel),
        .clk_out   (clk_out),
        .clk50_out (clk50_out),
        .pclk_out  (pclk_out),
        .osc_en    (osc_en)
    );

    // monitor: pops expected items and compares at +1 ns and +3.5 ns after each edge
    task automatic compare(bit h);
        logic [3:0] obs;
        obs = {clk_out, clk50_out, pclk_out, osc_en};
        while (sb_q.size() > 0 &&
               (sb_q[0].cyc < cyc || (sb_q[0].cyc == cyc && sb_q[0].half < h))) begin
            n_checks++;
            n_fail++;
            $display("FAIL %s: item for cycle %0d missed (actual cycle %0d, expected on time)",
                     sb_q[0].req, sb_q[0].cyc, cyc);
            void'(sb_q.pop_front());
        end
        while (sb_q.size() > 0 && sb_q[0].cyc == cyc && sb_q[0].half == h) begin
            n_checks++;
            if ((obs & sb_q[0].mask) !== (sb_q[0].exp & sb_q[0].mask)) begin
                n_fail++;
                $display("FAIL %s: cycle %0d half %0d actual {clk,clk50,pclk,osc}=%b expected %b mask %b",
                         sb_q[0].req, cyc, h, obs, sb_q[0].exp, sb_q[0].mask);
            end
            void'(sb_q.pop_front());
        end
    endtask

    initial begin
        forever begin
            @(posedge ref_clk);
            #1;
            cyc++;
            compare(1'b0);
            #2.5;
            compare(1'b1);
        end
    end

    // driver helpers
    task automatic tick(int n);
        repeat (n) @(posedge ref_clk);
        #2;
    endtask

    task automatic push(int c, bit h, logic [3:0] e, logic [3:0] m, string r);
        item_t it;
        it.cyc = c; it.half = h; it.exp = e; it.mask = m; it.req = r;
        sb_q.push_back(it);
    endtask

    // base = edge where the main clock falls; p0 = peripheral level before it
    task automatic expect_fast(int base, int n, logic p0, string r);
        for (int j = 0; j < n; j++) begin
            logic pc;
            pc = p0 ^ logic'(((j / 3) + 1) & 1);
            case (j % 3)
                0: begin push(base + j, 0, {1'b0, 1'b1, pc, 1'b0}, 4'b1110, r);
                         push(base + j, 1, 4'b0000, 4'b0100, r); end
                1: begin push(base + j, 0, {1'b0, 1'b0, pc, 1'b0}, 4'b1110, r);
                         push(base + j, 1, 4'b0000, 4'b0100, r); end
                default: begin push(base + j, 0, {1'b1, 1'b1, pc, 1'b0}, 4'b1110, r);
                         push(base + j, 1, 4'b0100, 4'b0100, r); end
            endcase
        end
    endtask

    task automatic wait_rise();
        logic prev;
        prev = clk_out;
        for (int g = 0; g < 400; g++) begin
            tick(1);
            if (clk_out && !prev) break;
            prev = clk_out;
        end
    endtask

    task automatic do_halt(output int h, output logic p);
        wait_rise();
        status = 3'b111;
        wait_rise();
        status = 3'b011;
        wait_rise();
        h = cyc;
        p = pclk_out;
        status = 3'b000;
    endtask

    // after a rise at edge c, a running fast clock falls at c+1 and rises at c+3
    task automatic expect_still_running(string r);
        wait_rise();
        push(cyc + 1, 0, 4'b0000, 4'b1000, r);
        push(cyc + 3, 0, 4'b1000, 4'b1000, r);
        tick(4);
    endtask

    task automatic do_reset(logic ext, logic slw);
        rst_n = 1'b0; src_ext = ext; slow_sel = slw;
        push(cyc + 2, 0, 4'b1101, 4'b1111, "R11");
        tick(3);
        rst_n = 1'b1;
    endtask

    initial begin
        int   h, s, r;
        logic p;

        // R11 reset state, then R1/R2 fast waveform
        do_reset(1'b1, 1'b0);
        r = cyc;
        expect_fast(r + 1, 30, 1'b0, "R1 R2");
        tick(31);

        // R4: lone stop code, and idle/other/stop, must not halt
        wait_rise(); status = 3'b011;
        wait_rise(); status = 3'b000;
        expect_still_running("R4");
        wait_rise(); status = 3'b111;
        wait_rise(); status = 3'b101;
        wait_rise(); status = 3'b011;
        wait_rise(); status = 3'b000;
        expect_still_running("R4");

        // R6: start high blocks the stop sequence; its rising edge does nothing
        start = 1'b1;
        wait_rise(); status = 3'b111;
        wait_rise(); status = 3'b011;
        wait_rise(); status = 3'b000;
        expect_still_running("R6");
        start = 1'b0;
        tick(2);

        // R10: source select changed after reset has no effect
        src_ext = 1'b0;

        // R4/R5/R7 halt with external source
        do_halt(h, p);
        for (int k = 1; k <= 10; k++) push(h + k, 0, {1'b1, 1'b1, p, 1'b1}, 4'b1111, "R5 R7 R10");
        tick(12);

        // R8 external restart
        start = 1'b1;
        s = cyc + 1;
        push(s + 1, 0, 4'b1000, 4'b1000, "R8");
        expect_fast(s + 2, 12, p, "R8");
        tick(15);
        start = 1'b0;

        // R11 reset during halt resumes running
        do_halt(h, p);
        tick(3);
        do_reset(1'b1, 1'b0);
        r = cyc;
        expect_fast(r + 1, 9, 1'b0, "R11");
        tick(10);

        // R7/R9 crystal source
        do_reset(1'b0, 1'b0);
        src_ext = 1'b1;
        do_halt(h, p);
        for (int k = 1; k <= 4; k++) push(h + k, 0, {1'b1, 1'b1, p, 1'b0}, 4'b1111, "R7");
        tick(6);
        start = 1'b1;
        s = cyc + 1;
        push(s + 1, 0, 4'b1101, 4'b1101, "R9 R7");
        push(s + WARM, 0, 4'b1100, 4'b1100, "R9");
        push(s + WARM + 1, 0, {1'b0, 1'b1, ~p, 1'b1}, 4'b1111, "R9");
        tick(WARM + 4);
        start = 1'b0;

        // R3 slow waveform
        do_reset(1'b1, 1'b1);
        r = cyc;
        push(r + 15, 0, 4'b1100, 4'b1100, "R3");
        push(r + 16, 0, 4'b0110, 4'b1110, "R3");
        push(r + 23, 0, 4'b0100, 4'b0100, "R3");
        push(r + 24, 0, 4'b0000, 4'b0100, "R3");
        push(r + 47, 0, 4'b0000, 4'b1000, "R3");
        push(r + 48, 0, 4'b1100, 4'b1100, "R3");
        tick(50);

        // R10: speed select change ignored, slow kept across halt/restart
        slow_sel = 1'b0;
        do_halt(h, p);
        tick(4);
        start = 1'b1;
        s = cyc + 1;
        push(s + 16, 0, 4'b1000, 4'b1000, "R10");
        push(s + 17, 0, 4'b0000, 4'b1000, "R10");
        tick(20);
        start = 1'b0;

        tick(5);
        if (sb_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL scoreboard: %0d items left (expected 0)", sb_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule